// File: doc/BRIEF.md
# Game Mode Controller with Speed Timer

This block runs the mode logic of a one-button arcade game and produces the tick that moves the obstacle across the screen. A single push button starts a game from the waiting mode. The same button pauses the game, resumes it, and clears a finished game. A collision input from the play-field logic ends the game. The button input is synchronised and filtered, and only a clean rising edge counts as a press.

While a game is in play, a two-stage divider builds a movement tick. The first stage divides the system clock down to a base rate. With a 50 MHz clock and the default divide-by-7813, that base rate is about 6.4 kHz. The second stage divides the base rate by a scaling value. Each new game starts the scaling value at 30. It drops by one for every second obstacle the player gets past, so the game speeds up, and it never falls below 1. Drawing, scoring and position arithmetic happen elsewhere. The obstacle logic moves one pixel for each tick.

Top module: `game_mode_ctrl`

## Requirements
- R1: While and right after the synchronous active-low reset, the mode output reads waiting (code 0), the scaling value reads SCALE_INIT (30) and no tick is emitted. The mode codes are 0 waiting, 1 playing, 2 paused, 3 finished.
- R2: The button counts only after its synchronised level has differed from the filtered level for DEBOUNCE_CYCLES consecutive clocks. A shorter glitch is ignored, and holding the button down gives exactly one press.
- R3: A press in waiting moves to playing and reloads the scaling value to SCALE_INIT.
- R4: A press in playing moves to paused, and a press in paused moves back to playing. The collision input is ignored in waiting and in paused.
- R5: The collision input held high for a clock in playing moves the mode to finished on that clock edge.
- R6: A press in finished returns the mode to waiting.
- R7: While playing, consecutive ticks are exactly BASE_DIV × scaling-value clocks apart (default BASE_DIV 7813).
- R8: No tick is emitted in waiting, paused or finished.
- R9: Each second obstacle-passed pulse seen while playing lowers the scaling value by one on that edge. Pulses outside playing are ignored.
- R10: The scaling value never drops below 1, and it never rises except on the reload of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| btn_raw | input | 1 | Unfiltered push-button level, asynchronous |
| collide | input | 1 | Player touches the obstacle (level, sampled each clock) |
| obst_passed | input | 1 | One-clock pulse each time an obstacle is cleared |
| move_tick | output | 1 | One-clock pulse: advance the obstacle by one pixel |
| game_state | output | 2 | Current mode: 0 waiting, 1 playing, 2 paused, 3 finished |
| speed_scale | output | $clog2(SCALE_INIT+1) | Current divider applied to the base rate |

## Verification
The assertions take the obstacle-passed and collision inputs to be synchronous to the clock, and the reset to be synchronous. They allow collision and passed pulses in any mode, so the ignore rules hold no matter what arrives. The bench changes every input at the falling clock edge. It builds button presses as holds longer than the filter window plus synchronisation, and it adds one deliberately short glitch. Tick spacing is measured only across stretches with no passed pulse, so the expected spacing matches a single scaling value.

// File: rtl/gm_pkg.sv
// Package: shared mode encoding for the game mode controller.
// Assumes: nothing beyond a 2-bit mode bus seen by neighbouring blocks.
package gm_pkg;

    typedef enum logic [1:0] {
        GM_IDLE  = 2'd0,
        GM_RUN   = 2'd1,
        GM_PAUSE = 2'd2,
        GM_OVER  = 2'd3
    } gm_state_e;

endpackage

// File: rtl/gm_btn_filter.sv
// Module: gm_btn_filter
// Synchronises an asynchronous push-button level and debounces it.
// The filtered level follows the input only after it has disagreed for
// STABLE_CYCLES consecutive clocks; a one-clock pulse marks each rising
// edge of the filtered level.
// Assumes: STABLE_CYCLES >= 1; reset is synchronous, active low.
module gm_btn_filter #(
    parameter int STABLE_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic press_o
);

    localparam int CW = (STABLE_CYCLES > 1) ? $clog2(STABLE_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(STABLE_CYCLES - 1);

    logic [1:0]    sync_q;
    logic          level_q;
    logic [CW-1:0] cnt_q;

    // Purpose: two-flop synchroniser for the raw button level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 2'b00;
        end else begin
            sync_q <= {sync_q[0], raw_i};
        end
    end

    // Purpose: count disagreement, accept a new level, flag rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            cnt_q   <= '0;
            press_o <= 1'b0;
        end else begin
            press_o <= 1'b0;
            if (sync_q[1] == level_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CNT_LAST) begin
                level_q <= sync_q[1];
                cnt_q   <= '0;
                press_o <= sync_q[1];
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/gm_mode_fsm.sv
// Module: gm_mode_fsm
// Four-mode game controller driven by a filtered press pulse and a
// collision level. Collision wins over a press in the playing mode.
// start_o is combinational and marks the edge on which play begins,
// so downstream reloads land on the same edge as the mode change.
// Assumes: press_i is a single-clock pulse.
module gm_mode_fsm
    import gm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      press_i,
    input  logic      collide_i,
    output gm_state_e state_o,
    output logic      start_o
);

    gm_state_e state_q;
    gm_state_e state_d;

    // Purpose: next-mode decision from current mode and events.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GM_IDLE:  if (press_i) state_d = GM_RUN;
            GM_RUN: begin
                if (collide_i)    state_d = GM_OVER;
                else if (press_i) state_d = GM_PAUSE;
            end
            GM_PAUSE: if (press_i) state_d = GM_RUN;
            GM_OVER:  if (press_i) state_d = GM_IDLE;
            default:  state_d = GM_IDLE;
        endcase
    end

    // Purpose: mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GM_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign start_o = (state_q == GM_IDLE) && press_i;
    assign state_o = state_q;

endmodule

// File: rtl/gm_speed_timer.sv
// Module: gm_speed_timer
// Two-stage tick divider with difficulty scaling. Stage one divides the
// clock by BASE_DIV while enabled; stage two divides those base ticks by
// the current scaling value. Every PASS_STEP passed pulses seen while
// enabled lower the scaling value by one, stopping at SCALE_MIN.
// Counters hold their phase while disabled and clear on restart_i.
// Assumes: BASE_DIV >= 1, 1 <= SCALE_MIN <= SCALE_INIT, PASS_STEP >= 1.
module gm_speed_timer #(
    parameter int BASE_DIV   = 7813,
    parameter int SCALE_INIT = 30,
    parameter int SCALE_MIN  = 1,
    parameter int PASS_STEP  = 2,
    localparam int SW        = $clog2(SCALE_INIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          restart_i,
    input  logic          passed_i,
    output logic          tick_o,
    output logic [SW-1:0] scale_o
);

    localparam int BW = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
    localparam int PW = $clog2(PASS_STEP + 1);
    localparam logic [SW-1:0] SCALE_RELOAD = SW'(SCALE_INIT);
    localparam logic [SW-1:0] SCALE_FLOOR  = SW'(SCALE_MIN);
    localparam logic [PW-1:0] PASS_LAST    = PW'(PASS_STEP - 1);

    logic          base_tick;
    logic [SW-1:0] scale_q;
    logic [SW-1:0] sub_q;
    logic [PW-1:0] pass_q;

    generate
        if (BASE_DIV > 1) begin : g_base_div
            localparam logic [BW-1:0] BASE_LAST = BW'(BASE_DIV - 1);
            logic [BW-1:0] base_q;

            // Purpose: stage-one counter producing base-rate pulses.
            always_ff @(posedge clk) begin
                if (!rst_n || restart_i) begin
                    base_q <= '0;
                end else if (en_i) begin
                    base_q <= (base_q == BASE_LAST) ? '0 : base_q + 1'b1;
                end
            end

            assign base_tick = en_i && (base_q == BASE_LAST);
        end else begin : g_base_pass
            assign base_tick = en_i;
        end
    endgenerate

    // Purpose: stage-two counter, emits a tick every scale_q base pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            sub_q  <= '0;
            tick_o <= 1'b0;
        end else begin
            tick_o <= 1'b0;
            if (base_tick) begin
                if (sub_q >= scale_q - 1'b1) begin
                    sub_q  <= '0;
                    tick_o <= 1'b1;
                end else begin
                    sub_q <= sub_q + 1'b1;
                end
            end
        end
    end

    // Purpose: difficulty scaling from the count of obstacles passed.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            scale_q <= SCALE_RELOAD;
            pass_q  <= '0;
        end else if (en_i && passed_i) begin
            if (pass_q == PASS_LAST) begin
                pass_q <= '0;
                if (scale_q > SCALE_FLOOR) begin
                    scale_q <= scale_q - 1'b1;
                end
            end else begin
                pass_q <= pass_q + 1'b1;
            end
        end
    end

    assign scale_o = scale_q;

endmodule

// File: rtl/game_mode_ctrl.sv
// Module: game_mode_ctrl (top)
// Game mode controller with obstacle speed timer. One debounced button
// steps the mode; a collision ends play; the speed timer runs only in
// the playing mode and restarts its difficulty on each new game.
// Assumes: collide and obst_passed are synchronous to clk; btn_raw may
// be asynchronous; reset is synchronous, active low.
module game_mode_ctrl
    import gm_pkg::*;
#(
    parameter int BASE_DIV        = 7813,
    parameter int SCALE_INIT      = 30,
    parameter int SCALE_MIN       = 1,
    parameter int PASS_STEP       = 2,
    parameter int DEBOUNCE_CYCLES = 250000,
    localparam int SW             = $clog2(SCALE_INIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          btn_raw,
    input  logic          collide,
    input  logic          obst_passed,
    output logic          move_tick,
    output logic [1:0]    game_state,
    output logic [SW-1:0] speed_scale
);

    logic      press;
    logic      start;
    gm_state_e state;

    gm_btn_filter #(
        .STABLE_CYCLES(DEBOUNCE_CYCLES)
    ) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (btn_raw),
        .press_o(press)
    );

    gm_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .press_i  (press),
        .collide_i(collide),
        .state_o  (state),
        .start_o  (start)
    );

    gm_speed_timer #(
        .BASE_DIV  (BASE_DIV),
        .SCALE_INIT(SCALE_INIT),
        .SCALE_MIN (SCALE_MIN),
        .PASS_STEP (PASS_STEP)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (state == GM_RUN),
        .restart_i(start),
        .passed_i (obst_passed),
        .tick_o   (move_tick),
        .scale_o  (speed_scale)
    );

    assign game_state = state;

endmodule

// File: rtl/gm_ctrl_checks.sv
// Module: gm_ctrl_checks
// Property checker for game_mode_ctrl, attached with bind below.
// Assumes: synchronous inputs and synchronous active-low reset.
module gm_ctrl_checks #(
    parameter int SCALE_INIT = 30,
    parameter int SCALE_MIN  = 1,
    localparam int SW        = $clog2(SCALE_INIT + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          collide,
    input logic          move_tick,
    input logic [1:0]    game_state,
    input logic [SW-1:0] speed_scale
);

    // R4: paused only ever leaves toward playing
    a_r4_pause_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(game_state) == 2'd2 && game_state != 2'd2) |-> game_state == 2'd1);

    // R4: collision in paused is ignored
    a_r4_pause_no_collide: assert property (@(posedge clk) disable iff (!rst_n)
        (game_state == 2'd2 && collide) |=> game_state != 2'd3);

    // R5: collision in playing ends the game
    a_r5_collide_over: assert property (@(posedge clk) disable iff (!rst_n)
        (game_state == 2'd1 && collide) |=> game_state == 2'd3);

    // R6: finished only ever leaves toward waiting
    a_r6_over_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(game_state) == 2'd3 && game_state != 2'd3) |-> game_state == 2'd0);

    // R8: a tick follows a cycle spent playing
    a_r8_tick_only_run: assert property (@(posedge clk) disable iff (!rst_n)
        move_tick |-> $past(game_state) == 2'd1);

    // R10: scaling value stays within its bounds
    a_r10_scale_range: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_scale >= SW'(SCALE_MIN)) && (speed_scale <= SW'(SCALE_INIT)));

    // R3/R10: scaling value rises only on the start of a game
    a_r10_rise_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_scale > $past(speed_scale)) |->
            ($past(game_state) == 2'd0 && speed_scale == SW'(SCALE_INIT)));

    // R9: a decrease is always a single step
    a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_scale < $past(speed_scale)) |-> speed_scale == $past(speed_scale) - 1'b1);

endmodule

bind game_mode_ctrl gm_ctrl_checks #(
    .SCALE_INIT(SCALE_INIT),
    .SCALE_MIN (SCALE_MIN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .collide    (collide),
    .move_tick  (move_tick),
    .game_state (game_state),
    .speed_scale(speed_scale)
);

// File: tb/game_mode_ctrl_tb.sv
module game_mode_ctrl_tb;

    localparam int BASE  = 5;
    localparam int INIT  = 30;
    localparam int DEB   = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       btn_raw = 1'b0;
    logic       collide = 1'b0;
    logic       obst_passed = 1'b0;
    logic       move_tick;
    logic [1:0] game_state;
    logic [4:0] speed_scale;

    int checks = 0;
    int fails  = 0;
    int exp_state = 0;
    int exp_scale = INIT;
    int exp_pass  = 0;

    always #5 clk = ~clk;

    game_mode_ctrl #(
        .BASE_DIV       (BASE),
        .SCALE_INIT     (INIT),
        .DEBOUNCE_CYCLES(DEB)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .btn_raw    (btn_raw),
        .collide    (collide),
        .obst_passed(obst_passed),
        .move_tick  (move_tick),
        .game_state (game_state),
        .speed_scale(speed_scale)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int next_on_press(input int s);
        case (s)
            0: return 1;
            1: return 2;
            2: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic int next_on_collide(input int s);
        return (s == 1) ? 3 : s;
    endfunction

    function automatic int expected_gap(input int sc);
        return BASE * sc;
    endfunction

    task automatic press_btn(input string req);
        if (exp_state == 0) begin
            exp_scale = INIT;
            exp_pass  = 0;
        end
        exp_state = next_on_press(exp_state);
        @(negedge clk) btn_raw = 1'b1;
        repeat (12) @(negedge clk);
        btn_raw = 1'b0;
        repeat (10) @(negedge clk);
        chk(game_state == 2'(exp_state), req, game_state, exp_state);
        chk(speed_scale == 5'(exp_scale), "R3 scale", speed_scale, exp_scale);
    endtask

    task automatic hit(input string req);
        @(negedge clk) collide = 1'b1;
        @(negedge clk) collide = 1'b0;
        exp_state = next_on_collide(exp_state);
        chk(game_state == 2'(exp_state), req, game_state, exp_state);
    endtask

    task automatic pass_one(input string req);
        @(negedge clk) obst_passed = 1'b1;
        @(negedge clk) obst_passed = 1'b0;
        if (exp_state == 1) begin
            exp_pass++;
            if (exp_pass == 2) begin
                exp_pass = 0;
                if (exp_scale > 1) exp_scale--;
            end
        end
        chk(speed_scale == 5'(exp_scale), req, speed_scale, exp_scale);
    endtask

    task automatic measure(input string req);
        int gap;
        int guard;
        if (exp_state == 1) begin
            guard = 0;
            while (!move_tick && guard < 400) begin
                @(negedge clk);
                guard++;
            end
            gap = 0;
            do begin
                @(negedge clk);
                gap++;
            end while (!move_tick && gap < 400);
            chk(gap == expected_gap(exp_scale), req, gap, expected_gap(exp_scale));
        end else begin
            gap = 0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (move_tick) gap++;
            end
            chk(gap == 0, "R8 no tick outside playing", gap, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(game_state == 2'd0, "R1 state", game_state, 0);
        chk(speed_scale == 5'd30, "R1 scale", speed_scale, 30);
        chk(move_tick == 1'b0, "R1 tick", move_tick, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(game_state == 2'd0, "R1 after release", game_state, 0);

        // R2: a short glitch is filtered out
        btn_raw = 1'b1;
        @(negedge clk) btn_raw = 1'b0;
        repeat (10) @(negedge clk);
        chk(game_state == 2'd0, "R2 glitch ignored", game_state, 0);

        // R4: collision while waiting ignored; R8: no ticks while waiting
        hit("R4 collide in waiting");
        measure("R8 waiting");

        // R2: a long hold yields a single press (waiting -> playing only)
        exp_state = 1;
        exp_scale = INIT;
        @(negedge clk) btn_raw = 1'b1;
        repeat (60) @(negedge clk);
        btn_raw = 1'b0;
        repeat (10) @(negedge clk);
        chk(game_state == 2'd1, "R2 hold one press", game_state, 1);

        // R7: tick spacing at the initial scale
        measure("R7 gap at start");

        // R4: pause, ignore collision and passes, resume
        press_btn("R4 pause");
        hit("R4 collide in paused");
        pass_one("R9 pass while paused ignored");
        measure("R8 paused");
        press_btn("R4 resume");

        // R9: passes lower the scale
        for (int i = 0; i < 4; i++) pass_one("R9 pass step");
        measure("R7 gap after passes");

        // R10: floor at 1
        for (int i = 0; i < 64; i++) pass_one("R10 floor");
        chk(speed_scale == 5'd1, "R10 at floor", speed_scale, 1);
        measure("R7 gap at floor");

        // R5, R6, R3: end, clear, restart reloads the scale
        hit("R5 collide in playing");
        measure("R8 finished");
        pass_one("R9 pass while finished ignored");
        press_btn("R6 clear finished");
        press_btn("R3 restart");
        chk(speed_scale == 5'd30, "R3 reload", speed_scale, 30);

        // Random mix of events
        for (int i = 0; i < 60; i++) begin
            int r;
            r = $urandom % 8;
            if (r < 2)      press_btn("R4 random press");
            else if (r == 2) hit("R5 random collide");
            else if (r < 6) pass_one("R9 random pass");
            else            measure("R7 random gap");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule